// File: doc/BRIEF.md
# Oversampled Serial Receiver with Noise and Framing Flags

This block receives asynchronous serial characters on a single input line. A sample enable that pulses at sixteen times the bit rate times every decision. While idle, the receiver looks for a high-to-low transition on the line. Once it sees one, it takes several samples across the start bit to confirm that it is a real start bit. It then shifts in eight data bits, least significant first, each decided by a three-sample majority vote near mid-bit, and it checks the stop bit.

Each finished character goes into a receive buffer together with two flags. The noise flag is set when any start-bit sample was high. The framing flag is set when the stop bit was sampled low. Software reads both flags through a two-address read port. A flag clears only after a status read that returned it as one, followed by a data read. Writes to the data address load a separate transmit holding register and never reach the receive buffer.

Top module: `orx_receiver`

## Requirements
- R1: While idle, a start is recognised when the synchronised line is low at a sample tick after being high at the previous sample tick. That tick counts as sample tick 1 of the start bit.
- R2: The start bit is sampled at ticks 1, 3, 5, 7, 8, 9 and 10 of 16. If any of these samples is high, the character's noise flag is set. Samples at other ticks have no effect.
- R3: If the majority of the start-bit samples at ticks 8, 9 and 10 is high, the character is abandoned. The buffer and flags are left unchanged and the receiver returns to the idle search.
- R4: Eight data bits are received least-significant bit first. Each bit is the majority of its samples at ticks 8, 9 and 10, so a single wrong sample among the three does not change the bit.
- R5: The framing flag is set when the stop-bit majority is low and clear when it is high. No other misframing check is made.
- R6: The receive buffer, noise flag and framing flag update together at the stop-bit decision, at tick 10 of the stop bit. The receiver is then idle again.
- R7: Address 0 reads status: bit 0 is the framing flag, bit 1 is the noise flag, and bits 7:2 are zero. Address 1 reads the receive buffer.
- R8: A flag clears when a status read that returned it as 1 is followed by a data read.
- R9: A data read with no qualifying status read before it leaves the flags unchanged. A character completing between the status read and the data read cancels the pending clear.
- R10: A write to address 1 loads the transmit holding output and leaves the receive buffer unchanged. A write to address 0 has no effect.
- R11: After reset, the status, the receive buffer and the transmit holding register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Sample enable, 16 per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tx_hold | output | 8 | Transmit holding register contents |

## Verification
The bench places single high samples on chosen start-bit ticks, both sampled and unsampled. A receiver that sampled the wrong ticks would therefore flag noise on clean characters or miss real glitches. It flips one of the three vote samples in every data bit, which a design taking a single sample per bit would decode wrongly. It also drives a runt start pulse, which a design without the mid-bit abandon would turn into a spurious character. The clearing checks read data without a status read first, and let a new character arrive between the two steps. A design that cleared on any data read, or kept a stale arm across a new character, would drop flags that belong to the buffered character.

// File: rtl/orx_pkg.sv
// Package: shared constants and types for the oversampled receiver.
// Assumes one character format: one start bit, ORX_DATA_W data bits, one stop bit.
package orx_pkg;

    localparam int ORX_DATA_W = 8;

    // Read/write port addresses
    localparam logic REG_STATUS = 1'b0;
    localparam logic REG_DATA   = 1'b1;

    // Status bit positions
    localparam int STAT_FE_BIT    = 0;
    localparam int STAT_NOISE_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } orx_state_e;

    typedef struct packed {
        logic [ORX_DATA_W-1:0] data;
        logic                  noise;
        logic                  frame_err;
    } orx_char_t;

endpackage

// File: rtl/orx_sync.sv
// Module: orx_sync
// Multi-stage synchroniser that brings the asynchronous line into the clock domain.
// Assumes STAGES >= 2. Resets to the idle (high) level so no false edge follows reset.
module orx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the register chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/orx_framer.sv
// Module: orx_framer
// Character framing state machine. It runs only on sample ticks (OVS per bit).
// It finds the start edge, checks the start bit, votes on the data and stop bits,
// and emits a one-cycle commit pulse with the character and its two flags.
// Assumes OVS >= 16, so that the early start samples fit before mid-bit.
module orx_framer
    import orx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = ORX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    output logic              commit,
    output orx_char_t         char_o,
    output orx_state_e        state_o
);

    localparam int PH_W  = $clog2(OVS);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    // Zero-based phases of the vote samples: ticks OVS/2, OVS/2+1, OVS/2+2
    localparam logic [PH_W-1:0] PH_V0 = PH_W'(OVS/2 - 1);
    localparam logic [PH_W-1:0] PH_V1 = PH_W'(OVS/2);
    localparam logic [PH_W-1:0] PH_V2 = PH_W'(OVS/2 + 1);
    // Early start-bit check samples in the first half of the bit
    localparam logic [PH_W-1:0] PH_E0 = PH_W'(OVS/2 - 6);
    localparam logic [PH_W-1:0] PH_E1 = PH_W'(OVS/2 - 4);
    localparam logic [PH_W-1:0] PH_E2 = PH_W'(OVS/2 - 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    orx_state_e         state;
    logic [PH_W-1:0]    phase;
    logic [PH_W-1:0]    phase_nxt;
    logic               wrap;
    logic [BIT_W-1:0]   bit_cnt;
    logic               prev_rx;
    logic               vote_a;
    logic               vote_b;
    logic               majority;
    logic               start_sample;
    logic               noise_acc;
    logic [DATA_W-1:0]  shreg;

    // Next phase, bit-boundary detect, vote majority and start-sample select
    always_comb begin
        wrap         = (phase == PH_LAST);
        phase_nxt    = wrap ? '0 : phase + 1'b1;
        majority     = (vote_a & vote_b) | (vote_a & rx) | (vote_b & rx);
        start_sample = (phase_nxt == PH_E0) || (phase_nxt == PH_E1) ||
                       (phase_nxt == PH_E2) || (phase_nxt == PH_V0) ||
                       (phase_nxt == PH_V1) || (phase_nxt == PH_V2);
    end

    // Framing sequencer: edge hunt, start check, data shift, stop decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= '0;
            bit_cnt   <= '0;
            prev_rx   <= 1'b1;
            vote_a    <= 1'b0;
            vote_b    <= 1'b0;
            noise_acc <= 1'b0;
            shreg     <= '0;
            commit    <= 1'b0;
            char_o    <= '0;
        end else begin
            commit <= 1'b0;
            if (tick) begin
                if (state == ST_IDLE) begin
                    prev_rx <= rx;
                    if (prev_rx && !rx) begin
                        state     <= ST_START;
                        phase     <= '0;
                        bit_cnt   <= '0;
                        noise_acc <= 1'b0;
                    end
                end else begin
                    phase <= phase_nxt;
                    if (phase_nxt == PH_V0) begin
                        vote_a <= rx;
                    end
                    if (phase_nxt == PH_V1) begin
                        vote_b <= rx;
                    end
                    if (state == ST_START && start_sample && rx) begin
                        noise_acc <= 1'b1;
                    end
                    if (phase_nxt == PH_V2) begin
                        unique case (state)
                            ST_START: begin
                                if (majority) begin
                                    state   <= ST_IDLE;
                                    prev_rx <= rx;
                                end
                            end
                            ST_DATA: begin
                                shreg <= {majority, shreg[DATA_W-1:1]};
                            end
                            ST_STOP: begin
                                commit           <= 1'b1;
                                char_o.data      <= shreg;
                                char_o.noise     <= noise_acc;
                                char_o.frame_err <= !majority;
                                state            <= ST_IDLE;
                                prev_rx          <= rx;
                            end
                            default: ;
                        endcase
                    end
                    if (wrap) begin
                        if (state == ST_START) begin
                            state   <= ST_DATA;
                            bit_cnt <= '0;
                        end else if (state == ST_DATA) begin
                            if (bit_cnt == BIT_LAST) begin
                                state <= ST_STOP;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    assign state_o = state;

endmodule

// File: rtl/orx_regs.sv
// Module: orx_regs
// Receive buffer, error flags with two-step clearing, transmit holding register
// and read-data multiplexer. Reads are combinational; their side effects take
// place at the clock edge that ends the read cycle.
// Assumes a read and a write are never strobed in the same cycle.
module orx_regs
    import orx_pkg::*;
#(
    parameter int DATA_W = ORX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  orx_char_t         char_i,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] tx_hold,
    output logic [DATA_W-1:0] rx_buf,
    output logic              noise_flag,
    output logic              fe_flag,
    output logic              arm_noise,
    output logic              arm_fe
);

    logic rd_status;
    logic rd_data;
    logic wr_data;
    logic [DATA_W-1:0] status_word;

    // Decode accesses and assemble the status word
    always_comb begin
        rd_status   = bus_rd && (bus_addr == REG_STATUS);
        rd_data     = bus_rd && (bus_addr == REG_DATA);
        wr_data     = bus_wr && (bus_addr == REG_DATA);
        status_word = '0;
        status_word[STAT_FE_BIT]    = fe_flag;
        status_word[STAT_NOISE_BIT] = noise_flag;
    end

    // Receive buffer, flags and clear-sequence arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf     <= '0;
            noise_flag <= 1'b0;
            fe_flag    <= 1'b0;
            arm_noise  <= 1'b0;
            arm_fe     <= 1'b0;
        end else if (commit) begin
            rx_buf     <= char_i.data;
            noise_flag <= char_i.noise;
            fe_flag    <= char_i.frame_err;
            arm_noise  <= 1'b0;
            arm_fe     <= 1'b0;
        end else if (rd_status) begin
            arm_noise <= noise_flag;
            arm_fe    <= fe_flag;
        end else if (rd_data) begin
            if (arm_noise) begin
                noise_flag <= 1'b0;
            end
            if (arm_fe) begin
                fe_flag <= 1'b0;
            end
            arm_noise <= 1'b0;
            arm_fe    <= 1'b0;
        end
    end

    // Transmit holding register, loaded by writes to the data address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
        end else if (wr_data) begin
            tx_hold <= bus_wdata;
        end
    end

    // Read-data multiplexer
    always_comb begin
        bus_rdata = (bus_addr == REG_DATA) ? rx_buf : status_word;
    end

endmodule

// File: rtl/orx_receiver.sv
// Module: orx_receiver (top)
// Oversampled serial receiver: synchroniser, framer and register block.
// Assumes os_tick pulses for one clock, OVS times per bit, and rxd idles high.
module orx_receiver
    import orx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = ORX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] tx_hold
);

    logic              rx_s;
    logic              frm_commit;
    orx_char_t         frm_char;
    orx_state_e        frm_state;
    logic [DATA_W-1:0] rx_buf;
    logic              noise_flag;
    logic              fe_flag;
    logic              arm_noise;
    logic              arm_fe;

    orx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    orx_framer #(
        .OVS    (OVS),
        .DATA_W (DATA_W)
    ) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .rx      (rx_s),
        .commit  (frm_commit),
        .char_o  (frm_char),
        .state_o (frm_state)
    );

    orx_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (frm_commit),
        .char_i     (frm_char),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tx_hold    (tx_hold),
        .rx_buf     (rx_buf),
        .noise_flag (noise_flag),
        .fe_flag    (fe_flag),
        .arm_noise  (arm_noise),
        .arm_fe     (arm_fe)
    );

endmodule

// File: rtl/orx_checks.sv
// Module: orx_checks
// Temporal properties for orx_receiver, attached through bind below.
module orx_checks
    import orx_pkg::*;
#(
    parameter int DATA_W = ORX_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              os_tick,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] tx_hold,
    input logic              frm_commit,
    input orx_state_e        frm_state,
    input logic [DATA_W-1:0] rx_buf,
    input logic              noise_flag,
    input logic              fe_flag,
    input logic              arm_noise,
    input logic              arm_fe
);

    p_tick_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick |=> $stable(frm_state));

    p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_commit |=> $stable(rx_buf));

    p_commit_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_commit |-> frm_state == ST_IDLE);

    p_status_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == REG_STATUS |-> bus_rdata[DATA_W-1:2] == '0);

    p_fe_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_commit && bus_rd && bus_addr == REG_DATA && arm_fe) |=> !fe_flag);

    p_noise_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_commit && bus_rd && bus_addr == REG_DATA && arm_noise) |=> !noise_flag);

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_commit && !(bus_rd && bus_addr == REG_DATA)) |=> $stable({noise_flag, fe_flag}));

    p_unarmed_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_commit && bus_rd && bus_addr == REG_DATA && !arm_fe && !arm_noise)
        |=> $stable({noise_flag, fe_flag}));

    p_tx_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA) |=> tx_hold == $past(bus_wdata));

endmodule

bind orx_receiver orx_checks #(.DATA_W(DATA_W)) i_orx_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_hold    (tx_hold),
    .frm_commit (frm_commit),
    .frm_state  (frm_state),
    .rx_buf     (rx_buf),
    .noise_flag (noise_flag),
    .fe_flag    (fe_flag),
    .arm_noise  (arm_noise),
    .arm_fe     (arm_fe)
);

// File: tb/test_orx_receiver.sv
module test_orx_receiver;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // Vector fields: [31:24] data, [23:16] data-glitch mask, [15:11] start glitch tick,
    // [10] stop level, [9] expected noise, [8] expected framing
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h55, 8'h00, 5'd0,  1'b1, 1'b0, 1'b0, 8'h00},
        {8'hA3, 8'h00, 5'd3,  1'b1, 1'b1, 1'b0, 8'h00},
        {8'h0F, 8'h00, 5'd2,  1'b1, 1'b0, 1'b0, 8'h00},
        {8'hC6, 8'h00, 5'd10, 1'b1, 1'b1, 1'b0, 8'h00},
        {8'h81, 8'h00, 5'd0,  1'b0, 1'b0, 1'b1, 8'h00},
        {8'h3C, 8'hFF, 5'd0,  1'b1, 1'b0, 1'b0, 8'h00},
        {8'h00, 8'h00, 5'd0,  1'b1, 1'b0, 1'b0, 8'h00},
        {8'hE7, 8'h5A, 5'd7,  1'b0, 1'b1, 1'b1, 8'h00},
        {8'hFF, 8'h00, 5'd11, 1'b1, 1'b0, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tx_hold;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    orx_receiver i_orx_receiver (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_hold   (tx_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One sample period: two clocks, tick on the first
    task automatic send_sample(input logic v);
        @(negedge clk);
        rxd = v;
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input int sg, input logic [7:0] dg,
                              input logic stop);
        for (int t = 1; t <= 16; t++) send_sample(t == sg);
        for (int i = 0; i < 8; i++)
            for (int t = 1; t <= 16; t++) send_sample(d[i] ^ (dg[i] && t == 9));
        for (int t = 1; t <= 16; t++) send_sample(stop);
        for (int t = 0; t < 4; t++) send_sample(1'b1);
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1;
        bus_addr = a;
        #(CLK_PERIOD/4);
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        bus_read(1'b0, rd); check("R11 status", rd, 8'h00);
        bus_read(1'b1, rd); check("R11 data", rd, 8'h00);
        check("R11 tx_hold", tx_hold, 8'h00);

        for (int t = 0; t < 8; t++) send_sample(1'b1);

        // Table walk: R2 noise, R4 data vote, R5 framing, R6/R7 result, R8 clear
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC[v][31:24], int'(VEC[v][15:11]), VEC[v][23:16], VEC[v][10]);
            bus_read(1'b0, rd);
            check("R2/R5/R7 status", rd, {6'b0, VEC[v][9], VEC[v][8]});
            bus_read(1'b1, rd);
            check("R4/R6 data", rd, VEC[v][31:24]);
            bus_read(1'b0, rd);
            check("R8 cleared", rd, 8'h00);
        end

        // R3: runt start pulse is abandoned
        send_frame(8'h5A, 0, 8'h00, 1'b1);
        bus_read(1'b1, rd); check("R4 data before runt", rd, 8'h5A);
        for (int t = 0; t < 5; t++) send_sample(1'b0);
        for (int t = 0; t < 24; t++) send_sample(1'b1);
        bus_read(1'b0, rd); check("R3 runt status", rd, 8'h00);
        bus_read(1'b1, rd); check("R3 runt data", rd, 8'h5A);
        // R1: receiver hunts again after abandon
        send_frame(8'h96, 0, 8'h00, 1'b1);
        bus_read(1'b1, rd); check("R1 recovery data", rd, 8'h96);

        // R9: data read without status read keeps flags
        send_frame(8'h42, 5, 8'h00, 1'b0);
        bus_read(1'b1, rd); check("R6 data", rd, 8'h42);
        bus_read(1'b0, rd); check("R9 flags kept", rd, 8'h03);
        bus_read(1'b1, rd);
        bus_read(1'b0, rd); check("R8 both cleared", rd, 8'h00);

        // R9: a new character between status read and data read cancels the clear
        send_frame(8'h11, 0, 8'h00, 1'b0);
        bus_read(1'b0, rd); check("R5 framing set", rd, 8'h01);
        send_frame(8'h22, 0, 8'h00, 1'b0);
        bus_read(1'b1, rd); check("R6 new data", rd, 8'h22);
        bus_read(1'b0, rd); check("R9 arm cancelled", rd, 8'h01);

        // R10: writes reach only the transmit holding register
        bus_write(1'b1, 8'hEE);
        bus_write(1'b0, 8'h77);
        check("R10 tx_hold", tx_hold, 8'hEE);
        bus_read(1'b0, rd); check("R10 status write ignored", rd, 8'h01);
        bus_read(1'b1, rd); check("R10 rx buffer kept", rd, 8'h22);
        bus_read(1'b0, rd); check("R8 cleared after sequence", rd, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule